// File: doc/BRIEF.md
# Serial Flash Command Engine

The block is a single-lane SPI master that runs one serial-flash command at a time. It is driven by a small byte-wide register port. Software sets an opcode and a pair of byte counts, one for bytes to send and one for bytes to receive. It fills an eight-entry byte FIFO through a data port that advances a pointer on each access, rewinds the pointer, and then sets an execute bit. The engine drops chip select, clocks out the opcode and the transmit bytes most significant bit first, then clocks in the requested number of receive bytes.

Transmit and receive data share the one FIFO. Each received byte is stored behind the transmit bytes, at the index equal to the transmit count plus its own position, wrapping modulo eight. To collect a response, software rewinds the pointer and reads past the transmit entries. While a command runs, the engine ignores the configuration and FIFO accesses that software attempts. The serial clock is derived from the system clock by a parameterised half-period divider, `DIV_HALF`.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, csN is high, sclk is low, and the opcode register, count register, FIFO pointer, every FIFO entry and the busy flag are all zero.
- R2: Address 0x0 holds the opcode and address 0x1 holds the counts, with the receive count in bits 7:4 and the transmit count in bits 3:0. Neither count includes the opcode. Both registers read back what was written.
- R3: A write to address 0xC stores the byte at FIFO[pointer], and a read returns that entry. Either access then advances the pointer by one, modulo 8. Address 0xD returns the pointer in bits 2:0.
- R4: Writing address 0x2 with bit 4 set returns the pointer to 0. Bit 4 always reads back as 0.
- R5: Writing address 0x2 with bit 0 set starts a command. Bit 0 of address 0x2 and bit 7 of address 0x3 read 1 while the command runs and 0 once it has finished.
- R6: A command holds csN low and sends the opcode, then FIFO entries 0 up to the transmit count minus one, then one 0x00 byte for each receive byte. Bits go out MSB first in mode 0: sclk idles low, mosi changes only while sclk is low, and miso is sampled on the rising edge.
- R7: Receive byte k is stored in FIFO[(transmit count + k) mod 8].
- R8: When both counts are zero, the frame is exactly the 8 opcode bits.
- R9: Busy stays high for exactly (16*(1+tx+rx)+1)*DIV_HALF clock cycles after the start write, and csN is high whenever busy is low.
- R10: While busy, the engine ignores writes to 0x0, 0x1 and 0xC, pointer resets and further start requests. Reads of 0xC made while busy do not move the pointer.
- R11: Running a command does not change the FIFO pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Read strobe; advances the pointer on a 0xC read |
| regRdData | output | 8 | Combinational read data for regAddr |
| sclk | output | 1 | SPI serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Read data is combinational, so every register check samples one time unit after a falling clock edge, with the address applied at that edge. A write or a pointer-advancing read takes effect at the next rising edge, and the effect is checked at the following falling edge. Busy rises at the rising edge that takes the start write and stays high for (16*(1+tx+rx)+1)*DIV_HALF cycles. The bench counts the falling edges at which status bit 7 is set and compares that count exactly. FIFO contents and the pointer are checked only after busy has fallen.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W      = 4;
  localparam int ADDR_W     = 4;

  localparam logic [ADDR_W-1:0] ADDR_OPCODE = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 4'hC;
  localparam logic [ADDR_W-1:0] ADDR_PTR    = 4'hD;

  localparam int EXEC_BIT = 0;
  localparam int PRST_BIT = 4;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic             loadOp;
    logic             loadTx;
    logic             loadZero;
    logic             sample;
    logic             shift;
    logic             storeRx;
    logic [PTR_W-1:0] txIdx;
    logic [PTR_W-1:0] rxIdx;
  } engStrobe_t;
endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  output logic             busy,
  output logic             sclk,
  output logic             csN,
  output engStrobe_t       strb
);
  localparam int DIV_W  = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BYTE_W = CNT_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_TAIL} ctrlState_t;

  ctrlState_t        state;
  logic [DIV_W-1:0]  divCnt;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] byteNum;
  logic              sclkQ;
  logic              csNQ;
  logic              divHit;
  logic [BYTE_W-1:0] lastByte;
  logic [BYTE_W-1:0] txWide;

  assign divHit   = (divCnt == DIV_W'(DIV_HALF - 1));
  assign txWide   = BYTE_W'(txCnt);
  assign lastByte = txWide + BYTE_W'(rxCnt);
  assign busy     = (state != ST_IDLE);
  assign sclk     = sclkQ;
  assign csN      = csNQ;

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: strb.loadOp = start;
      ST_XFER: begin
        if (divHit) begin
          if (!sclkQ) begin
            strb.sample = 1'b1;
          end else if (bitCnt == 3'd7) begin
            strb.storeRx = (byteNum > txWide);
            strb.rxIdx   = PTR_W'(byteNum - BYTE_W'(1));
            if (byteNum != lastByte) begin
              if (byteNum < txWide) begin
                strb.loadTx = 1'b1;
                strb.txIdx  = PTR_W'(byteNum);
              end else begin
                strb.loadZero = 1'b1;
              end
            end
          end else begin
            strb.shift = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      byteNum <= '0;
      sclkQ   <= 1'b0;
      csNQ    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_XFER;
            csNQ    <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
            byteNum <= '0;
            sclkQ   <= 1'b0;
          end
        end
        ST_XFER: begin
          if (divHit) begin
            divCnt <= '0;
            if (!sclkQ) begin
              sclkQ <= 1'b1;
            end else begin
              sclkQ <= 1'b0;
              if (bitCnt == 3'd7) begin
                bitCnt <= '0;
                if (byteNum == lastByte) state <= ST_TAIL;
                else byteNum <= byteNum + BYTE_W'(1);
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_TAIL: begin
          if (divHit) begin
            divCnt <= '0;
            csNQ   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              busy,
  input  engStrobe_t        strb,
  input  logic              miso,
  output logic [CNT_W-1:0]  txCnt,
  output logic [CNT_W-1:0]  rxCnt,
  output logic              start,
  output logic              shiftMsb,
  output logic [DATA_W-1:0] opcode,
  output logic [PTR_W-1:0]  ptr
);
  logic [DATA_W-1:0] opcodeQ;
  logic [DATA_W-1:0] countQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [DATA_W-1:0] shiftQ;
  logic              misoQ;
  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];

  logic swWr, ptrRst, dataWr, dataRd;
  logic [DATA_W-1:0] rxByte;

  assign swWr   = regWrEn && !busy;
  assign start  = swWr && (regAddr == ADDR_CTRL) && regWrData[EXEC_BIT];
  assign ptrRst = swWr && (regAddr == ADDR_CTRL) && regWrData[PRST_BIT];
  assign dataWr = swWr && (regAddr == ADDR_DATA);
  assign dataRd = regRdEn && !busy && (regAddr == ADDR_DATA);
  assign rxByte = {shiftQ[DATA_W-2:0], misoQ};

  assign txCnt    = countQ[CNT_W-1:0];
  assign rxCnt    = countQ[DATA_W-1:CNT_W];
  assign shiftMsb = shiftQ[DATA_W-1];
  assign opcode   = opcodeQ;
  assign ptr      = ptrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ <= '0;
      countQ  <= '0;
      ptrQ    <= '0;
    end else begin
      if (swWr && regAddr == ADDR_OPCODE) opcodeQ <= regWrData;
      if (swWr && regAddr == ADDR_COUNT)  countQ  <= regWrData;
      if (ptrRst) ptrQ <= '0;
      else if (dataWr || dataRd) ptrQ <= ptrQ + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FIFO_DEPTH; i++) fifoMem[i] <= '0;
    end else if (strb.storeRx) begin
      fifoMem[strb.rxIdx] <= rxByte;
    end else if (dataWr) begin
      fifoMem[ptrQ] <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      misoQ  <= 1'b0;
    end else begin
      if (strb.sample) misoQ <= miso;
      if (strb.loadOp)        shiftQ <= opcodeQ;
      else if (strb.loadTx)   shiftQ <= fifoMem[strb.txIdx];
      else if (strb.loadZero) shiftQ <= '0;
      else if (strb.shift)    shiftQ <= rxByte;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_OPCODE: regRdData = opcodeQ;
      ADDR_COUNT:  regRdData = countQ;
      ADDR_CTRL:   regRdData = {{(DATA_W-1){1'b0}}, busy};
      ADDR_STATUS: regRdData = {busy, {(DATA_W-1){1'b0}}};
      ADDR_DATA:   regRdData = fifoMem[ptrQ];
      ADDR_PTR:    regRdData = {{(DATA_W-PTR_W){1'b0}}, ptrQ};
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  engStrobe_t        strb;
  logic              busyW;
  logic              startW;
  logic              shiftMsbW;
  logic [CNT_W-1:0]  txCntW;
  logic [CNT_W-1:0]  rxCntW;
  logic [DATA_W-1:0] opcodeW;
  logic [PTR_W-1:0]  ptrW;

  spi_cmd_ctrl #(.DIV_HALF(DIV_HALF)) ctrlInst (
    .clk(clk), .rstN(rstN), .start(startW), .txCnt(txCntW), .rxCnt(rxCntW),
    .busy(busyW), .sclk(sclk), .csN(csN), .strb(strb)
  );

  spi_cmd_dp dpInst (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .busy(busyW), .strb(strb), .miso(miso), .txCnt(txCntW), .rxCnt(rxCntW),
    .start(startW), .shiftMsb(shiftMsbW), .opcode(opcodeW), .ptr(ptrW)
  );

  assign mosi = !csN && shiftMsbW;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
  import spi_cmd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              csN,
  input logic              sclk,
  input logic              mosi,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] opcode,
  input logic [PTR_W-1:0]  ptr
);
  // R9
  csn_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R5
  start_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && regAddr == ADDR_CTRL && regWrData[EXEC_BIT]));

  // R10
  op_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == ADDR_OPCODE) |=> $stable(opcode));

  // R10 R11
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ptr));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk chkInst (
  .clk(clk), .rstN(rstN), .busy(busyW), .csN(csN), .sclk(sclk), .mosi(mosi),
  .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
  .opcode(opcodeW), .ptr(ptrW)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  localparam int DIV = 2;
  localparam int NVEC = 6;
  // {opcode, tx, rx, seed}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h06_00_00, 24'h05_01_40, 24'h90_32_11,
    24'h02_70_A5, 24'h9F_17_3C, 24'h0B_46_C3
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sclk, csN, mosi, miso;

  int checks = 0, fails = 0;
  int cycles = 0;
  logic [7:0] mdl [8];
  logic [7:0] capBytes [32];
  logic [7:0] capSh;
  int sByte = 0, sBit = 0, frameCnt = 0;
  logic [7:0] curSeed = '0;
  logic [7:0] rb;

  always #4 clk = ~clk;

  spi_cmd_engine #(.DIV_HALF(DIV)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] respByte(input logic [7:0] seed, input int k);
    return seed ^ (8'h5A + 8'(k * 19));
  endfunction

  // flash model
  always @(negedge csN) begin sByte = 0; sBit = 0; frameCnt++; end
  always @(posedge sclk) if (!csN) begin
    capSh = {capSh[6:0], mosi};
    sBit++;
    if (sBit == 8) begin
      if (sByte < 32) capBytes[sByte] = capSh;
      sByte++;
      sBit = 0;
    end
  end
  always @* begin
    rb = respByte(curSeed, sByte);
    miso = csN ? 1'b0 : rb[3'(7 - sBit)];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, input logic adv, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = adv;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    regAddr = 4'h3;
    for (int i = 0; i < 5000; i++) begin
      #1;
      if (!regRdData[7]) break;
      @(negedge clk);
    end
  endtask

  task automatic startAndTime(output int cnt);
    @(negedge clk);
    regAddr = 4'h2; regWrData = 8'h01; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 4'h3;
    cnt = 0;
    for (int i = 0; i < 5000; i++) begin
      #1;
      if (!regRdData[7]) break;
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic runCmd(input logic [7:0] op, input int tx, input int rx, input logic [7:0] seed);
    logic [7:0] txv [8];
    logic [7:0] d;
    int cnt, fc0, mptr;
    regWrite(4'h2, 8'h10);
    regWrite(4'h0, op);
    regWrite(4'h1, {4'(rx), 4'(tx)});
    mptr = 0;
    for (int i = 0; i < tx; i++) begin
      txv[i] = seed + 8'(i * 7);
      regWrite(4'hC, txv[i]);
      mdl[mptr] = txv[i];
      mptr = (mptr + 1) % 8;
    end
    regWrite(4'h2, 8'h10);
    curSeed = seed;
    fc0 = frameCnt;
    startAndTime(cnt);
    // R9 exact busy length
    check("R9 busy cycles", cnt, (16 * (1 + tx + rx) + 1) * DIV);
    check("R9 csN after done", int'(csN), 1);
    check("R6 one frame", frameCnt, fc0 + 1);
    // R8 frame length (opcode only when both counts zero)
    check("R8 frame bytes", sByte, 1 + tx + rx);
    check("R6 opcode first", int'(capBytes[0]), int'(op));
    for (int i = 0; i < tx; i++) check("R6 tx byte", int'(capBytes[1 + i]), int'(txv[i]));
    for (int k = 0; k < rx; k++) begin
      check("R6 rx filler", int'(capBytes[1 + tx + k]), 0);
      mdl[(tx + k) % 8] = respByte(seed, 1 + tx + k);
    end
    regRead(4'hD, 1'b0, d);
    check("R11 pointer kept", int'(d), 0);
    regRead(4'h0, 1'b0, d);
    check("R2 opcode readback", int'(d), int'(op));
    regRead(4'h1, 1'b0, d);
    check("R2 count readback", int'(d), int'({4'(rx), 4'(tx)}));
    for (int i = 0; i < 8; i++) begin
      regRead(4'hC, 1'b1, d);
      check("R7 fifo entry", int'(d), int'(mdl[i]));
    end
    regRead(4'hD, 1'b0, d);
    check("R3 pointer wraps to 0", int'(d), 0);
  endtask

  initial begin
    logic [7:0] d;
    int fc0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1;
    check("R1 csN", int'(csN), 1);
    check("R1 sclk", int'(sclk), 0);
    regRead(4'h3, 1'b0, d); check("R1 busy", int'(d), 0);
    regRead(4'hD, 1'b0, d); check("R1 pointer", int'(d), 0);
    regRead(4'h0, 1'b0, d); check("R1 opcode", int'(d), 0);
    regRead(4'h1, 1'b0, d); check("R1 counts", int'(d), 0);
    for (int i = 0; i < 8; i++) begin
      regRead(4'hC, 1'b1, d); check("R1 fifo zero", int'(d), 0);
    end

    // R4 pointer reset
    regWrite(4'hC, 8'hA1); regWrite(4'hC, 8'hA2); regWrite(4'hC, 8'hA3);
    mdl[0] = 8'hA1; mdl[1] = 8'hA2; mdl[2] = 8'hA3;
    regRead(4'hD, 1'b0, d); check("R3 pointer after 3 writes", int'(d), 3);
    regWrite(4'h2, 8'h10);
    regRead(4'hD, 1'b0, d); check("R4 pointer reset", int'(d), 0);
    regRead(4'h2, 1'b0, d); check("R4 reset bit reads 0", int'(d), 0);
    regRead(4'hC, 1'b1, d); check("R3 data read", int'(d), 8'hA1);
    // R3 wrap on writes: 9 writes land entry 0 last
    regWrite(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) begin
      regWrite(4'hC, 8'(8'h30 + i));
      mdl[i % 8] = 8'(8'h30 + i);
    end
    regRead(4'hD, 1'b0, d); check("R3 pointer mod 8", int'(d), 1);
    regWrite(4'h2, 8'h10);
    regRead(4'hC, 1'b1, d); check("R3 wrapped write", int'(d), 8'h38);

    // table of commands
    for (int vi = 0; vi < NVEC; vi++)
      runCmd(VEC[vi][23:16], int'(VEC[vi][15:12]), int'(VEC[vi][11:8]), VEC[vi][7:0]);

    // R10 accesses while busy, R5 status bits
    regWrite(4'h2, 8'h10);
    regWrite(4'h0, 8'h33);
    regWrite(4'h1, 8'h20);
    curSeed = 8'h77;
    fc0 = frameCnt;
    regWrite(4'h2, 8'h01);
    regRead(4'h2, 1'b0, d); check("R5 exec bit set", int'(d), 1);
    regRead(4'h3, 1'b0, d); check("R5 busy bit set", int'(d), 8'h80);
    regWrite(4'h0, 8'hEE);
    regWrite(4'h1, 8'h77);
    regWrite(4'hC, 8'h99);
    regRead(4'hC, 1'b1, d);
    regWrite(4'h2, 8'h11);
    waitIdle();
    repeat (300) @(negedge clk);
    check("R10 no restart", frameCnt, fc0 + 1);
    regRead(4'h2, 1'b0, d); check("R5 exec bit clear", int'(d), 0);
    regRead(4'h0, 1'b0, d); check("R10 opcode kept", int'(d), 8'h33);
    regRead(4'h1, 1'b0, d); check("R10 counts kept", int'(d), 8'h20);
    regRead(4'hD, 1'b0, d); check("R10 pointer kept", int'(d), 0);
    regRead(4'hC, 1'b1, d); check("R10 R7 rx0 not overwritten", int'(d), int'(respByte(8'h77, 1)));
    regRead(4'hC, 1'b1, d); check("R7 rx1", int'(d), int'(respByte(8'h77, 2)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule